// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits beside a shared free-running timer. It watches the timer count, which it receives on an input bus, and uses a single 16-bit holding register in one of two ways. In compare mode the register is a threshold. When the count reaches it, the channel raises an event and can drive a one-bit output high, drive it low or invert it. In capture mode the register is a timestamp latch. A chosen input, either source A or source B, is brought into the clock domain. A qualifying transition on that input copies the current count into the register.

Every event, whether a match or a capture, sets a sticky event flag. Software clears that flag. The flag is gated by an enable bit to form the interrupt request. A capture that lands while the previous timestamp has not yet been read sets an overflow bit. Several copies of the block can share one timer. Each copy has its own configuration word.

Top module: `tmr_cc_channel`

## Requirements
- R1: While reset is asserted and right after it, the holding register reads 0, the event flag, the overflow bit and the interrupt request are 0, and the compare output equals the parameter OUT_INIT (default 0).
- R2: A configuration write stores the 7-bit word at the next rising edge, and it governs behaviour from the following cycle on. Its fields are: bit 0 selects capture mode (1) or compare mode (0); bit 1 selects source B (1) or source A (0); bits 3:2 hold the edge select; bits 5:4 hold the output action; bit 6 is the interrupt enable.
- R3: A software write loads the holding register at the next rising edge. When a capture falls in the same cycle, the captured count is stored and the written value is dropped.
- R4: In capture mode, the selected input passes through a two-flop synchronizer. A transition first seen at rising edge k stores the count presented at rising edge k+2.
- R5: The edge select codes are: 00, never capture; 01, low-to-high only; 10, high-to-low only; 11, both directions.
- R6: In compare mode, a match event happens in any cycle where the count equals the holding register and did not equal it in the previous cycle.
- R7: On a match event the output action is applied at that clock edge. The codes are: 00, output unchanged; 01, output set to 1; 10, output cleared to 0; 11, output inverted. At all other times the output holds.
- R8: Any event sets the event flag. The clear strobe clears it. When an event and a clear arrive in the same cycle, the flag ends up set.
- R9: The overflow bit is set when a capture occurs while the previous capture is still unread. The read strobe marks the value as read. A read in the same cycle as a capture consumes the old value and does not cause an overflow. The overflow clear strobe clears the bit, but a new overflow in the same cycle takes priority.
- R10: The interrupt request equals the event flag ANDed with the interrupt enable, with no extra cycle of delay.
- R11: In compare mode, input transitions never capture. In capture mode, count matches set no flag and leave the output alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_count | input | CNT_W | Shared timer count |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration word |
| ccr_we | input | 1 | Holding register write strobe |
| ccr_wdata | input | CNT_W | Holding register write data |
| ccr_rd | input | 1 | Marks the captured value as read |
| flag_clr | input | 1 | Clears the event flag |
| ovf_clr | input | 1 | Clears the overflow bit |
| cap_in_a | input | 1 | Capture source A |
| cap_in_b | input | 1 | Capture source B |
| ccr_q | output | CNT_W | Holding register contents |
| cc_flag | output | 1 | Sticky event flag |
| cc_ovf | output | 1 | Capture overflow bit |
| cc_irq | output | 1 | Interrupt request |
| cmp_out | output | 1 | Compare output |

## Verification
Two kinds of same-cycle collision matter here. The first is an event arriving in the same cycle that software clears the flag. The second is a capture arriving in the same cycle that software reads the holding register or writes it. The random stimulus issues clear, read and write strobes at high rates. It also steers software writes so the register lands just ahead of the count, so matches and captures often coincide with those strobes. A directed case schedules a match exactly on a clear cycle. A cycle-accurate model in the bench is derived from the priority rules in R3, R8 and R9, and every cycle the flag, the overflow bit and the register contents are compared against it.

// File: rtl/cc_pkg.sv
package cc_pkg;

   typedef enum logic [1:0] {
      EDG_NONE = 2'b00,
      EDG_RISE = 2'b01,
      EDG_FALL = 2'b10,
      EDG_BOTH = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'b00,
      ACT_SET  = 2'b01,
      ACT_CLR  = 2'b10,
      ACT_TGL  = 2'b11
   } out_act_e;

   // bit 6 .. bit 0
   typedef struct packed {
      logic      irq_en;
      out_act_e  act;
      edge_sel_e esel;
      logic      src_b;
      logic      cap_mode;
   } cc_cfg_t;

   localparam int CFG_W = $bits(cc_cfg_t);

endpackage

// File: rtl/cc_edge_detect.sv
module cc_edge_detect
   import cc_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sin,
   input  edge_sel_e esel,
   input  logic      arm,
   output logic      hit
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("cc_edge_detect: STAGES must be at least 2");
   end

   // pipe[0..LAST] synchronizer, pipe[STAGES] previous level
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= 1'b0;
      else        pipe[0] <= sin;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[i] <= 1'b0;
         else        pipe[i] <= pipe[i-1];
      end
   end

   logic now_lvl, old_lvl, rise, fall;
   assign now_lvl = pipe[LAST];
   assign old_lvl = pipe[STAGES];
   assign rise    = now_lvl & ~old_lvl;
   assign fall    = ~now_lvl & old_lvl;

   always_comb begin
      unique case (esel)
         EDG_RISE: hit = arm & rise;
         EDG_FALL: hit = arm & fall;
         EDG_BOTH: hit = arm & (rise | fall);
         default:  hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/cc_out_action.sv
module cc_out_action
   import cc_pkg::*;
#(
   parameter bit OUT_INIT = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ev,
   input  out_act_e act,
   output logic     q
);

   logic q_nxt;

   always_comb begin
      q_nxt = q;
      if (ev) begin
         unique case (act)
            ACT_SET: q_nxt = 1'b1;
            ACT_CLR: q_nxt = 1'b0;
            ACT_TGL: q_nxt = ~q;
            default: q_nxt = q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= OUT_INIT;
      else        q <= q_nxt;
   end

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ev |=> $stable(q));

endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel
   import cc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_INIT    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tmr_count,
   input  logic             cfg_we,
   input  logic [6:0]       cfg_wdata,
   input  logic             ccr_we,
   input  logic [CNT_W-1:0] ccr_wdata,
   input  logic             ccr_rd,
   input  logic             flag_clr,
   input  logic             ovf_clr,
   input  logic             cap_in_a,
   input  logic             cap_in_b,
   output logic [CNT_W-1:0] ccr_q,
   output logic             cc_flag,
   output logic             cc_ovf,
   output logic             cc_irq,
   output logic             cmp_out
);

   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_cc_channel: CNT_W must be at least 2");
   end
   if (CFG_W != 7) begin : g_bad_cfg
      $error("tmr_cc_channel: configuration word must be 7 bits");
   end

   cc_cfg_t cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= '0;
      else if (cfg_we) cfg <= cc_cfg_t'(cfg_wdata);
   end

   // capture path
   logic sel_in, cap_ev;
   assign sel_in = cfg.src_b ? cap_in_b : cap_in_a;

   cc_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sin  (sel_in),
      .esel (cfg.esel),
      .arm  (cfg.cap_mode),
      .hit  (cap_ev)
   );

   // compare path
   logic match, match_d, cmp_ev;
   assign match  = (tmr_count == ccr_q);
   assign cmp_ev = ~cfg.cap_mode & match & ~match_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_d <= 1'b0;
      else        match_d <= match;
   end

   // holding register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ccr_q <= '0;
      else if (cap_ev) ccr_q <= tmr_count;
      else if (ccr_we) ccr_q <= ccr_wdata;
   end

   // flag, unread tracking, overflow
   logic unread;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc_flag <= 1'b0;
         unread  <= 1'b0;
         cc_ovf  <= 1'b0;
      end else begin
         if (cap_ev | cmp_ev) cc_flag <= 1'b1;
         else if (flag_clr)   cc_flag <= 1'b0;

         if (cap_ev)      unread <= 1'b1;
         else if (ccr_rd) unread <= 1'b0;

         if (cap_ev & unread & ~ccr_rd) cc_ovf <= 1'b1;
         else if (ovf_clr)              cc_ovf <= 1'b0;
      end
   end

   assign cc_irq = cc_flag & cfg.irq_en;

   cc_out_action #(.OUT_INIT(OUT_INIT)) u_out (
      .clk  (clk),
      .rst_n(rst_n),
      .ev   (cmp_ev),
      .act  (cfg.act),
      .q    (cmp_out)
   );

   // R4
   cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_ev |=> (ccr_q == $past(tmr_count)));

   // R3
   sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_we && !cap_ev) |=> (ccr_q == $past(ccr_wdata)));

   // R8
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ev || cmp_ev) |=> cc_flag);

   // R9
   ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cc_ovf) |-> $past(cap_ev));

   // R11
   mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap_ev && cmp_ev));

endmodule

// File: tb/tb_tmr_cc_channel.sv
module tb_tmr_cc_channel;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tmr_count = '0;
   logic         cfg_we = 0, ccr_we = 0, ccr_rd = 0, flag_clr = 0, ovf_clr = 0;
   logic [6:0]   cfg_wdata = '0;
   logic [W-1:0] ccr_wdata = '0;
   logic         cap_in_a = 0, cap_in_b = 0;
   logic [W-1:0] ccr_q;
   logic         cc_flag, cc_ovf, cc_irq, cmp_out;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tmr_cc_channel dut (
      .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .ccr_we(ccr_we), .ccr_wdata(ccr_wdata), .ccr_rd(ccr_rd),
      .flag_clr(flag_clr), .ovf_clr(ovf_clr),
      .cap_in_a(cap_in_a), .cap_in_b(cap_in_b),
      .ccr_q(ccr_q), .cc_flag(cc_flag), .cc_ovf(cc_ovf),
      .cc_irq(cc_irq), .cmp_out(cmp_out)
   );

   // reference state
   logic [6:0]   m_cfg = '0;
   logic [W-1:0] m_ccr = '0;
   logic         m_flag = 0, m_ovf = 0, m_unread = 0, m_out = 0, m_md = 0;
   logic [2:0]   m_pipe = '0;

   function automatic logic edge_ok(input logic [1:0] es, input logic now_l, input logic old_l);
      if (now_l == old_l) return 1'b0;
      case (es)
         2'b01:   return now_l;
         2'b10:   return !now_l;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic act_apply(input logic [1:0] act, input logic q);
      case (act)
         2'b01:   return 1'b1;
         2'b10:   return 1'b0;
         2'b11:   return !q;
         default: return q;
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // compute next reference state from inputs now applied, advance one clock, compare
   task automatic step();
      logic sel, hit, mt, cev;
      sel = m_cfg[1] ? cap_in_b : cap_in_a;
      hit = m_cfg[0] && edge_ok(m_cfg[3:2], m_pipe[1], m_pipe[2]);
      mt  = (m_ccr == tmr_count);
      cev = !m_cfg[0] && mt && !m_md;
      if (hit && m_unread && !ccr_rd) m_ovf = 1'b1;
      else if (ovf_clr)               m_ovf = 1'b0;
      if (hit)         m_unread = 1'b1;
      else if (ccr_rd) m_unread = 1'b0;
      if (hit || cev)    m_flag = 1'b1;
      else if (flag_clr) m_flag = 1'b0;
      if (cev) m_out = act_apply(m_cfg[5:4], m_out);
      m_md = mt;
      if (hit)         m_ccr = tmr_count;
      else if (ccr_we) m_ccr = ccr_wdata;
      if (cfg_we) m_cfg = cfg_wdata;
      m_pipe = {m_pipe[1:0], sel};
      @(posedge clk);
      @(negedge clk);
      check("R3/R4/R5/R11", "ccr_q", ccr_q, m_ccr);
      check("R2/R6/R8/R11", "cc_flag", W'(cc_flag), W'(m_flag));
      check("R9", "cc_ovf", W'(cc_ovf), W'(m_ovf));
      check("R10", "cc_irq", W'(cc_irq), W'(m_flag & m_cfg[6]));
      check("R6/R7", "cmp_out", W'(cmp_out), W'(m_out));
   endtask

   task automatic idle_strobes();
      cfg_we = 0; ccr_we = 0; ccr_rd = 0; flag_clr = 0; ovf_clr = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "ccr_q", ccr_q, '0);
      check("R1", "flag", W'(cc_flag), '0);
      check("R1", "ovf", W'(cc_ovf), '0);
      check("R1", "irq", W'(cc_irq), '0);
      check("R1", "out", W'(cmp_out), '0);
      rst_n = 1'b1;
      step();

      // directed R7/R8: compare mode, toggle action, irq on; match lands on a clear cycle
      cfg_we = 1; cfg_wdata = 7'b1_11_00_0_0;
      step(); idle_strobes();
      tmr_count = 16'd100; ccr_we = 1; ccr_wdata = 16'd103;
      step(); idle_strobes();
      for (int i = 0; i < 3; i++) begin
         tmr_count = tmr_count + 1'b1;
         flag_clr = (tmr_count == 16'd103);
         step();
      end
      idle_strobes();
      check("R8", "set beats clear", W'(cc_flag), 1);
      check("R7", "toggle on match", W'(cmp_out), 1);

      // directed R9: capture on A both edges, two captures with no read
      cfg_we = 1; cfg_wdata = 7'b0_00_11_0_1;
      step(); idle_strobes();
      for (int i = 0; i < 8; i++) begin
         if (i == 0 || i == 4) cap_in_a = ~cap_in_a;
         tmr_count = tmr_count + 1'b1;
         step();
      end
      check("R9", "overflow after unread capture", W'(cc_ovf), 1);

      // constrained random
      for (int n = 0; n < 6000; n++) begin
         idle_strobes();
         if ($urandom_range(0, 15) == 0) begin
            cfg_we = 1; cfg_wdata = 7'($urandom);
         end
         if ($urandom_range(0, 11) == 0) begin
            ccr_we = 1; ccr_wdata = tmr_count + W'($urandom_range(0, 6));
         end
         ccr_rd   = ($urandom_range(0, 4) == 0);
         flag_clr = ($urandom_range(0, 3) == 0);
         ovf_clr  = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 3) == 0) cap_in_a = ~cap_in_a;
         if ($urandom_range(0, 3) == 0) cap_in_b = ~cap_in_b;
         case ($urandom_range(0, 9))
            0:       tmr_count = W'($urandom);
            1, 2:    tmr_count = tmr_count;
            default: tmr_count = tmr_count + 1'b1;
         endcase
         step();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule